// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a small direct-mapped cache. It sits between a word-addressed processor port and a slower word-wide memory port. The cache is built from a power-of-two number of slots. Each slot keeps a multi-word line together with a tag, a valid flag and a dirty flag. A word address is split into three fields, from the top bit down: tag, slot index, and word offset within the line. Memory block `n` therefore always lands in slot `n mod SLOTS`.

A hit completes in one cycle. A read miss fetches the whole line from memory, starting at word 0 and going up. The requested word is handed to the processor in the cycle after it arrives, even while the rest of the line is still loading. Writes are write-back with write-allocate. A write hit only touches the cache and marks the line dirty. A write miss loads the line and merges the new word into it. When a miss lands on a dirty slot, every word of the old line is written back before the new line is requested. Two saturating counters record how many accepted requests hit and how many missed, so hit ratios can be measured.

The processor raises `cpuReq` with `cpuWe`, `cpuAddr` and `cpuWdata`. A request is taken on a rising clock edge where `cpuBusy` is low. Completion is signalled by a one-cycle `cpuDone` pulse, with `cpuRdata` valid in the same cycle for reads.

Top module: `dm_cache`

## Requirements
- R1: After reset every slot is empty: the first access to any address misses, `cpuBusy` and `memReq` are low, and both counters read 0.
- R2: With the default geometry (10-bit address, 4 slots, 16-word lines) the word offset is address bits [3:0], the slot is bits [5:4] and the tag is bits [9:6]; line transfers use memory address {tag, slot, offset}.
- R3: A read request accepted on a hit produces `cpuDone` with the stored word on `cpuRdata` in the next cycle, with no memory transaction and `cpuBusy` staying low.
- R4: A miss raises `cpuBusy` from the cycle after acceptance until the line fill finishes. The fill issues exactly one memory read per line word, at offsets 0 up to the last. Requests presented while `cpuBusy` is high are not accepted.
- R5: On a read miss, `cpuDone` and the requested word appear in the cycle after the memory acknowledge for that word (load-through). `cpuBusy` is still high at that point unless the word is the last one in the line.
- R6: A write hit updates only the cache: no memory transaction occurs, and later reads return the new value.
- R7: A write miss first allocates the line through a full fill, then merges the written word. `cpuDone` pulses after the acknowledge of that word, and later reads of the address return the written value.
- R8: A miss on a slot holding a valid dirty line first writes all line words of the victim (offsets ascending, at the victim's own tag) to memory, carrying the cached values, before any read of the new line.
- R9: A miss on a clean or empty slot performs no memory write.
- R10: Each accepted request adds one to exactly one of `hitCount` or `missCount`. Each counter stops at its all-ones value.
- R11: `memReq` stays high with `memAddr`, `memWe` and `memWdata` unchanged until `memAck`. Each acknowledged cycle moves exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request valid |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Write data |
| cpuRdata | output | DATA_W | Read data, valid with cpuDone |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuBusy | output | 1 | Miss in progress; requests not accepted |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = memory write (flush), 0 = read (fill) |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Flush data |
| memRdata | input | DATA_W | Fill data, sampled with memAck |
| memAck | input | 1 | Memory accepts/returns one word |
| hitCount | output | CNT_W | Saturating hit count |
| missCount | output | CNT_W | Saturating miss count |

## Verification
Some internal faults show up at the ports within one access. A corrupted tag or valid flag turns an expected hit into a memory fill, or the reverse. A wrong word counter moves the `cpuDone` pulse relative to the acknowledge of the requested word. Other faults only show up when a line is evicted: a lost dirty flag removes the 16 write-backs, and stale line data appears in the written-back words or on a later read. Bench-side shadow tags and a shadow of the processor-visible memory predict every hit or miss, every transaction sequence and every returned word, so each fault is caught on the access that exposes it.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_FILL
  } cacheState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic latchReq;    // capture request fields
    logic hitRead;     // load read data from the array
    logic hitWrite;    // write the array on a hit, mark dirty
    logic flushPhase;  // memory address uses the victim tag
    logic fillWord;    // store one returned word into the line
    logic fillDone;    // last word stored: install tag and flags
    logic deliver;     // requested word arrived during the fill
  } ctrlStrobes_t;

endpackage

// File: rtl/dm_cache_datapath.sv
module dm_cache_datapath
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int SLOT_BITS = 2,
  parameter int WORD_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobes_t         strobes,
  input  logic [WORD_BITS-1:0] wordCnt,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic                 cpuWe,
  input  logic [DATA_W-1:0]    cpuWdata,
  input  logic [DATA_W-1:0]    memRdata,
  output logic                 lookupHit,
  output logic                 victimDirty,
  output logic [WORD_BITS-1:0] reqWord,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  output logic [DATA_W-1:0]    cpuRdata
);
  localparam int TAG_W = ADDR_W - SLOT_BITS - WORD_BITS;
  localparam int SLOTS = 1 << SLOT_BITS;
  localparam int WORDS = 1 << WORD_BITS;

  logic [TAG_W-1:0]  tagArr   [SLOTS];
  logic [SLOTS-1:0]  validArr;
  logic [SLOTS-1:0]  dirtyArr;
  logic [DATA_W-1:0] lineMem  [SLOTS][WORDS];

  logic [TAG_W-1:0]     inTag;
  logic [SLOT_BITS-1:0] inSlot;
  logic [WORD_BITS-1:0] inWord;
  assign {inTag, inSlot, inWord} = cpuAddr;

  logic [TAG_W-1:0]     reqTag;
  logic [SLOT_BITS-1:0] reqSlot;
  logic                 reqWe;
  logic [DATA_W-1:0]    reqWdata;

  // Per-slot tag compare
  logic [SLOTS-1:0] slotHit;
  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    assign slotHit[s] = validArr[s] && (tagArr[s] == inTag);
  end
  assign lookupHit   = slotHit[inSlot];
  assign victimDirty = validArr[inSlot] && dirtyArr[inSlot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqTag   <= '0;
      reqSlot  <= '0;
      reqWord  <= '0;
      reqWe    <= 1'b0;
      reqWdata <= '0;
    end else if (strobes.latchReq) begin
      reqTag   <= inTag;
      reqSlot  <= inSlot;
      reqWord  <= inWord;
      reqWe    <= cpuWe;
      reqWdata <= cpuWdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validArr <= '0;
      dirtyArr <= '0;
      for (int s = 0; s < SLOTS; s++) tagArr[s] <= '0;
    end else if (strobes.hitWrite) begin
      dirtyArr[inSlot] <= 1'b1;
    end else if (strobes.fillDone) begin
      validArr[reqSlot] <= 1'b1;
      dirtyArr[reqSlot] <= reqWe;
      tagArr[reqSlot]   <= reqTag;
    end
  end

  logic mergeHere;
  assign mergeHere = reqWe && (wordCnt == reqWord);

  always_ff @(posedge clk) begin
    if (strobes.hitWrite)
      lineMem[inSlot][inWord] <= cpuWdata;
    else if (strobes.fillWord)
      lineMem[reqSlot][wordCnt] <= mergeHere ? reqWdata : memRdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cpuRdata <= '0;
    else if (strobes.hitRead)
      cpuRdata <= lineMem[inSlot][inWord];
    else if (strobes.deliver)
      cpuRdata <= reqWe ? reqWdata : memRdata;
  end

  assign memAddr  = {(strobes.flushPhase ? tagArr[reqSlot] : reqTag), reqSlot, wordCnt};
  assign memWdata = lineMem[reqSlot][wordCnt];

endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import dm_cache_pkg::*;
#(
  parameter int WORD_BITS = 4,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpuReq,
  input  logic                 cpuWe,
  input  logic                 lookupHit,
  input  logic                 victimDirty,
  input  logic [WORD_BITS-1:0] reqWord,
  input  logic                 memAck,
  output ctrlStrobes_t         strobes,
  output logic [WORD_BITS-1:0] wordCnt,
  output logic                 memReq,
  output logic                 memWe,
  output logic                 cpuBusy,
  output logic                 cpuDone,
  output logic [CNT_W-1:0]     hitCount,
  output logic [CNT_W-1:0]     missCount
);
  cacheState_t state, nextState;
  logic accept, lastWord;

  assign accept   = (state == ST_IDLE) && cpuReq;
  assign lastWord = &wordCnt;
  assign cpuBusy  = (state != ST_IDLE);

  always_comb begin
    strobes   = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: if (cpuReq) begin
        strobes.latchReq = 1'b1;
        strobes.hitRead  = lookupHit && !cpuWe;
        strobes.hitWrite = lookupHit && cpuWe;
        if (!lookupHit) nextState = victimDirty ? ST_FLUSH : ST_FILL;
      end
      ST_FLUSH: begin
        memReq             = 1'b1;
        memWe              = 1'b1;
        strobes.flushPhase = 1'b1;
        if (memAck && lastWord) nextState = ST_FILL;
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strobes.fillWord = 1'b1;
          strobes.deliver  = (wordCnt == reqWord);
          if (lastWord) begin
            strobes.fillDone = 1'b1;
            nextState        = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wordCnt   <= '0;
      cpuDone   <= 1'b0;
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      state   <= nextState;
      cpuDone <= (accept && lookupHit) || strobes.deliver;
      if (accept)
        wordCnt <= '0;
      else if (memReq && memAck)
        wordCnt <= wordCnt + 1'b1;
      if (accept && lookupHit && !(&hitCount))
        hitCount <= hitCount + 1'b1;
      if (accept && !lookupHit && !(&missCount))
        missCount <= missCount + 1'b1;
    end
  end

endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int SLOT_BITS = 2,
  parameter int WORD_BITS = 4,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuDone,
  output logic              cpuBusy,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  ctrlStrobes_t         strobes;
  logic [WORD_BITS-1:0] wordCnt;
  logic [WORD_BITS-1:0] reqWord;
  logic                 lookupHit;
  logic                 victimDirty;

  dm_cache_ctrl #(.WORD_BITS(WORD_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rst_n, .cpuReq, .cpuWe, .lookupHit, .victimDirty, .reqWord,
    .memAck, .strobes, .wordCnt, .memReq, .memWe, .cpuBusy, .cpuDone,
    .hitCount, .missCount
  );

  dm_cache_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_BITS(SLOT_BITS), .WORD_BITS(WORD_BITS)
  ) u_dp (
    .clk, .rst_n, .strobes, .wordCnt, .cpuAddr, .cpuWe, .cpuWdata, .memRdata,
    .lookupHit, .victimDirty, .reqWord, .memAddr, .memWdata, .cpuRdata
  );

endmodule

// File: rtl/dm_cache_sva.sv
module dm_cache_sva #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpuReq,
  input logic              cpuBusy,
  input logic              cpuDone,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck,
  input logic [CNT_W-1:0]  hitCount,
  input logic [CNT_W-1:0]  missCount
);
  // R4: an accepted request either completes at once or stalls
  a_r4_accept_resolves: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuReq && !cpuBusy) |=> (cpuDone || cpuBusy));

  // R1: no memory traffic while the cache is not handling a miss
  a_r1_idle_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    !cpuBusy |-> !memReq);

  // R11: request held steady until acknowledged
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R11: flush data held steady until acknowledged
  a_r11_wdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe && !memAck) |=> $stable(memWdata));

  // R10: counters move only on an edge with a request present
  a_r10_quiet_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    !cpuReq |=> ($stable(hitCount) && $stable(missCount)));

  // R10: counters hold once saturated
  a_r10_hit_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (&hitCount) |=> (&hitCount));

  a_r10_miss_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (&missCount) |=> (&missCount));

endmodule

bind dm_cache dm_cache_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cpuReq(cpuReq), .cpuBusy(cpuBusy), .cpuDone(cpuDone),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
  .memAck(memAck), .hitCount(hitCount), .missCount(missCount)
);

// File: tb/dm_cache_tb.sv
module dm_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;
  localparam int MEM_WORDS = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic [DATA_W-1:0] cpuRdata;
  logic cpuDone, cpuBusy, memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata = '0;
  logic memAck = 1'b0;
  logic [CNT_W-1:0] hitCount, missCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_cache u_dut (
    .clk, .rst_n, .cpuReq, .cpuWe, .cpuAddr, .cpuWdata, .cpuRdata, .cpuDone,
    .cpuBusy, .memReq, .memWe, .memAddr, .memWdata, .memRdata, .memAck,
    .hitCount, .missCount
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [DATA_W-1:0] mem    [MEM_WORDS];
  logic [DATA_W-1:0] refMem [MEM_WORDS];
  logic       refValid [4];
  logic       refDirty [4];
  logic [3:0] refTag   [4];
  int expHit = 0, expMiss = 0;

  int logCount = 0;
  logic              logWe   [64];
  logic [ADDR_W-1:0] logAddr [64];
  logic [DATA_W-1:0] logData [64];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Memory model: random 0..2 cycle wait, one-cycle acknowledge per word
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (waitCnt == 0) begin
          if (logCount < 64) begin
            logWe[logCount]   = memWe;
            logAddr[logCount] = memAddr;
            logData[logCount] = memWdata;
          end
          logCount++;
          if (memWe) mem[memAddr] = memWdata;
          else memRdata = mem[memAddr];
          memAck  = 1'b1;
          waitCnt = $urandom_range(0, 2);
        end else waitCnt--;
      end
    end
  end

  task automatic clearRef();
    for (int s = 0; s < 4; s++) begin
      refValid[s] = 0; refDirty[s] = 0; refTag[s] = '0;
    end
    expHit = 0; expMiss = 0;
  endtask

  task automatic doReset();
    rst_n = 1'b0; cpuReq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    clearRef();
    for (int i = 0; i < MEM_WORDS; i++) refMem[i] = mem[i];
  endtask

  // One processor access with full prediction and checking; starts and ends at a negedge.
  task automatic step(input logic we, input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wdata);
    int slot, word, base, bad;
    logic [3:0] tag, oldTag;
    bit hit, dirtyV, busyAtDone;
    int transAtDone;
    logic [DATA_W-1:0] rdata;
    slot = addr[5:4]; word = addr[3:0]; tag = addr[9:6];
    hit = refValid[slot] && (refTag[slot] == tag);
    dirtyV = !hit && refValid[slot] && refDirty[slot];
    oldTag = refTag[slot];
    while (cpuBusy) @(negedge clk);
    logCount = 0;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wdata;
    do @(negedge clk); while (!cpuDone);
    rdata = cpuRdata; busyAtDone = cpuBusy; transAtDone = logCount;
    cpuReq = 1'b0;
    while (cpuBusy) @(negedge clk);

    if (!we) check(rdata == refMem[addr], hit ? "R3 read data" : "R5 read data", rdata, refMem[addr]);
    if (hit) begin
      check(logCount == 0, we ? "R6 no memory traffic" : "R3 no memory traffic", logCount, 0);
      check(!busyAtDone, "R3 not busy", busyAtDone, 0);
    end else begin
      base = dirtyV ? 16 : 0;
      check(logCount == base + 16, "R11 one word per ack", logCount, base + 16);
      check(transAtDone == base + word + 1, we ? "R7 done at word" : "R5 load-through timing",
            transAtDone, base + word + 1);
      check(busyAtDone == (word != 15), "R5 busy at done", busyAtDone, word != 15);
      bad = 0;
      for (int k = 0; k < 16; k++)
        if (logWe[base+k] || logAddr[base+k] != {tag, 2'(slot), 4'(k)}) bad++;
      check(bad == 0, "R2 R4 fill addresses", bad, 0);
      bad = 0;
      if (dirtyV) begin
        for (int k = 0; k < 16; k++) begin
          if (!logWe[k] || logAddr[k] != {oldTag, 2'(slot), 4'(k)} ||
              logData[k] != refMem[{oldTag, 2'(slot), 4'(k)}]) bad++;
        end
        check(bad == 0, "R8 victim flush", bad, 0);
      end else begin
        for (int k = 0; k < 16; k++) if (logWe[k]) bad++;
        check(bad == 0, "R9 clean victim no writes", bad, 0);
      end
    end

    if (we) refMem[addr] = wdata;
    if (hit) begin
      if (we) refDirty[slot] = 1;
      if (expHit < 65535) expHit++;
    end else begin
      refValid[slot] = 1; refTag[slot] = tag; refDirty[slot] = we;
      if (expMiss < 65535) expMiss++;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = DATA_W'(i * 37 + 16'h0A00);
    doReset();

    // R1: reset state
    check(!cpuBusy, "R1 busy low", cpuBusy, 0);
    check(!memReq, "R1 memReq low", memReq, 0);
    check(hitCount == 0 && missCount == 0, "R1 counters zero", hitCount + missCount, 0);

    // R10: classic trace, 48..95 then ten passes over 15..31
    for (int a = 48; a <= 95; a++) step(1'b0, ADDR_W'(a), '0);
    for (int p = 0; p < 10; p++)
      for (int a = 15; a <= 31; a++) step(1'b0, ADDR_W'(a), '0);
    check(hitCount == 213, "R10 trace hits", hitCount, 213);
    check(missCount == 5, "R10 trace misses", missCount, 5);

    // Directed: write hit (R6), dirty eviction (R8), clean refetch (R9), write miss (R7)
    step(1'b1, 10'h005, 16'hBEEF);
    step(1'b0, 10'h005, '0);
    step(1'b0, 10'h105, '0);
    check(mem[10'h005] == 16'hBEEF, "R8 written back", mem[10'h005], 16'hBEEF);
    step(1'b0, 10'h005, '0);
    step(1'b1, 10'h2AF, 16'h1234);
    step(1'b0, 10'h2AF, '0);
    step(1'b1, 10'h3E0, 16'h0F0F);

    // Random mix over a conflicting address range
    for (int n = 0; n < 300; n++)
      step(1'($urandom_range(0, 1)), ADDR_W'($urandom_range(0, 255)), DATA_W'($urandom));
    check(hitCount == CNT_W'(expHit), "R10 hit count", hitCount, expHit);
    check(missCount == CNT_W'(expMiss), "R10 miss count", missCount, expMiss);

    // R10 saturation: hold a read request on one address
    doReset();
    check(hitCount == 0 && missCount == 0, "R1 counters after reset", hitCount + missCount, 0);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 10'h010;
    repeat (66000) @(negedge clk);
    cpuReq = 1'b0;
    while (cpuBusy) @(negedge clk);
    @(negedge clk);
    check(missCount == 1, "R1 R4 single miss then held request", missCount, 1);
    check(hitCount == 16'hFFFF, "R10 hit saturation", hitCount, 65535);

    finishRun();
  end
endmodule